// File: doc/BRIEF.md
# Nibble-Serial Register Command Decoder

This block takes 8-bit command bytes from a host link over a valid/ready handshake. It turns them into accesses to an internal byte-wide register file and into request pulses for an external sample-memory controller. The upper four bits of each byte select the operation and the lower four bits carry an operand.

A full register address or a full data byte takes two commands, one nibble each. A read command returns the addressed byte on a separate valid/ready output channel. A step mode can move the address up or down by one after each access, so a host can sweep a range of registers without reloading the address. Memory commands produce one-cycle request pulses with a bank flag. A wait command stalls the command input until the controller reports that the outstanding operation has finished.

Top module: `nibcmd_decoder`

## Requirements
- R1: A command is accepted on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. Bits [7:4] of `cmd_byte` are the opcode and bits [3:0] are the operand. `cmd_ready` is high after reset.
- R2: Opcode 0x0 puts the operand into address bits [3:0]. Opcode 0x1 puts it into address bits [7:4]. The other address nibble does not change.
- R3: Opcode 0x2 keeps the operand as the low data nibble. Opcode 0x3 writes {operand, low nibble} into the register at the current address.
- R4: Opcode 0x4 returns the register at the current address on `rd_data` with `rd_valid` high, starting the cycle after acceptance. The value holds until a clock edge with `rd_ready` high. `cmd_ready` stays low while `rd_valid` is high.
- R5: Each read loads the step mode from its operand: bit 0 enables a step and bit 1 picks the direction (1 is down, 0 is up). That mode applies to the read itself and to every later 0x3 write until the next read. A step changes the address by one modulo 256, in time for the next command.
- R6: Opcodes 0x6/0x7 pulse `mem_req_xfer`, 0x8/0x9 pulse `mem_req_first` and 0xA/0xB pulse `mem_req_full`. Each pulse lasts exactly one cycle, in the cycle after acceptance. `mem_bank` then equals opcode bit 0 (command byte bit 4).
- R7: A memory request is outstanding from its pulse until a cycle with `mem_done` high. Opcode 0x5 accepted while a request is outstanding holds `cmd_ready` low until `mem_done` is seen. With nothing outstanding, 0x5 is consumed with no stall.
- R8: Opcodes 0xC to 0xF are consumed and change neither the address, the data nibble, the registers nor any output.
- R9: Reset (`rst_n` low) clears the address, data nibble, step mode (no step), register contents, pending wait, outstanding flag and read channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Decoder can accept a command |
| cmd_byte | input | 8 | Opcode [7:4], operand [3:0] |
| rd_valid | output | 1 | Read result present |
| rd_ready | input | 1 | Host takes the read result |
| rd_data | output | 8 | Read result byte |
| mem_req_xfer | output | 1 | Pulse: move a block from bulk memory to block RAM |
| mem_req_first | output | 1 | Pulse: read the leading bytes of the block |
| mem_req_full | output | 1 | Pulse: read the whole block |
| mem_bank | output | 1 | Buffer half chosen by the last memory request |
| mem_done | input | 1 | Memory controller finished the outstanding operation |

## Verification
The assertions assume the host keeps to the handshake rules and issues at most one command per cycle. They also assume `mem_done` is a level sampled on clock edges, which may come at any time. The stall assertion relies on this: while the wait is pending no command is accepted, so no new request can start. The bench drives every input on the falling edge. It raises `mem_done` only after a request has been issued, and it holds `rd_ready` low for several cycles on purpose to exercise back-pressure. It sweeps all 256 addresses, each direction of stepping and wrap-around, and every memory and unused opcode.

// File: rtl/nibcmd_pkg.sv
package nibcmd_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  localparam logic [NIB_W-1:0] OP_ADDR_LO = 4'h0;
  localparam logic [NIB_W-1:0] OP_ADDR_HI = 4'h1;
  localparam logic [NIB_W-1:0] OP_DATA_LO = 4'h2;
  localparam logic [NIB_W-1:0] OP_DATA_WR = 4'h3;
  localparam logic [NIB_W-1:0] OP_READ    = 4'h4;
  localparam logic [NIB_W-1:0] OP_WAIT    = 4'h5;
  localparam logic [NIB_W-1:0] OP_MEM_LO  = 4'h6;
  localparam logic [NIB_W-1:0] OP_MEM_HI  = 4'hB;

  localparam int N_MEM_KINDS = 3;
endpackage

// File: rtl/nibcmd_addr_unit.sv
module nibcmd_addr_unit #(
  parameter int NIB_W  = 4,
  localparam int ADDR_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [NIB_W-1:0]  nib,
  input  logic              mode_ld,
  input  logic [1:0]        mode_in,
  input  logic              step_en,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [1:0]        mode_q, mode_d, mode_eff;

  always_comb begin
    mode_eff = mode_ld ? mode_in : mode_q;
    mode_d   = mode_eff;
    addr_d   = addr_q;
    if (ld_lo) addr_d[NIB_W-1:0] = nib;
    if (ld_hi) addr_d[ADDR_W-1:NIB_W] = nib;
    if (step_en && mode_eff[0]) begin
      if (mode_eff[1]) addr_d = addr_q - ADDR_W'(1);
      else             addr_d = addr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= 2'b00;
    end else begin
      addr_q <= addr_d;
      mode_q <= mode_d;
    end
  end

  assign addr = addr_q;

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && mode_eff == 2'b01) |=> (addr == $past(addr) + ADDR_W'(1))); // R5
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && mode_eff == 2'b11) |=> (addr == $past(addr) - ADDR_W'(1))); // R5
  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_lo && !ld_hi && !step_en) |=> $stable(addr)); // R8
endmodule

// File: rtl/nibcmd_regfile.sv
module nibcmd_regfile #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data))); // R3
endmodule

// File: rtl/nibcmd_mem_req.sv
module nibcmd_mem_req #(
  parameter int N_KINDS = 3,
  localparam int KIND_W = $clog2(N_KINDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [KIND_W-1:0] kind,
  input  logic              bank,
  input  logic              wait_cmd,
  input  logic              mem_done,
  output logic [N_KINDS-1:0] pulse,
  output logic              bank_out,
  output logic              wait_block
);
  logic busy_q, busy_d;
  logic wait_q, wait_d;
  logic bank_q;

  always_comb begin
    busy_d = busy_q;
    if (mem_done) busy_d = 1'b0;
    if (issue)    busy_d = 1'b1;
    if (wait_q) wait_d = !mem_done;
    else        wait_d = wait_cmd && busy_q && !mem_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      wait_q <= wait_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank_q <= 1'b0;
    else if (issue) bank_q <= bank;
  end

  for (genvar k = 0; k < N_KINDS; k++) begin : g_kind
    logic pulse_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= issue && (kind == KIND_W'(k));
    end
    assign pulse[k] = pulse_q;
  end

  assign bank_out   = bank_q;
  assign wait_block = wait_q;

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse)); // R6
  AST_WAIT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |-> busy_q); // R7
  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && mem_done) |=> !wait_q); // R7
endmodule

// File: rtl/nibcmd_decoder.sv
module nibcmd_decoder
  import nibcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic              mem_req_xfer,
  output logic              mem_req_first,
  output logic              mem_req_full,
  output logic              mem_bank,
  input  logic              mem_done
);
  localparam int KIND_W = $clog2(N_MEM_KINDS);

  logic [NIB_W-1:0]  op, arg;
  logic              accept;
  logic              is_mem;
  logic [NIB_W-1:0]  mem_rel;
  logic [KIND_W-1:0] kind;
  logic [BYTE_W-1:0] addr, rf_rd;
  logic [NIB_W-1:0]  dlo_q, dlo_d;
  logic              rdv_q, rdv_d;
  logic [BYTE_W-1:0] rdd_q, rdd_d;
  logic              wait_block;
  logic [N_MEM_KINDS-1:0] pulses;

  assign op      = cmd_byte[BYTE_W-1:NIB_W];
  assign arg     = cmd_byte[NIB_W-1:0];
  assign accept  = cmd_valid && cmd_ready;
  assign is_mem  = (op >= OP_MEM_LO) && (op <= OP_MEM_HI);
  assign mem_rel = op - OP_MEM_LO;
  assign kind    = mem_rel[KIND_W:1];

  nibcmd_addr_unit #(.NIB_W(NIB_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_lo   (accept && op == OP_ADDR_LO),
    .ld_hi   (accept && op == OP_ADDR_HI),
    .nib     (arg),
    .mode_ld (accept && op == OP_READ),
    .mode_in (arg[1:0]),
    .step_en (accept && (op == OP_READ || op == OP_DATA_WR)),
    .addr    (addr)
  );

  nibcmd_regfile #(.ADDR_W(BYTE_W), .DATA_W(BYTE_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept && op == OP_DATA_WR),
    .wr_addr (addr),
    .wr_data ({arg, dlo_q}),
    .rd_addr (addr),
    .rd_data (rf_rd)
  );

  nibcmd_mem_req #(.N_KINDS(N_MEM_KINDS)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (accept && is_mem),
    .kind       (kind),
    .bank       (op[0]),
    .wait_cmd   (accept && op == OP_WAIT),
    .mem_done   (mem_done),
    .pulse      (pulses),
    .bank_out   (mem_bank),
    .wait_block (wait_block)
  );

  always_comb begin
    dlo_d = dlo_q;
    rdv_d = rdv_q;
    rdd_d = rdd_q;
    if (accept && op == OP_DATA_LO) dlo_d = arg;
    if (rdv_q && rd_ready) rdv_d = 1'b0;
    if (accept && op == OP_READ) begin
      rdv_d = 1'b1;
      rdd_d = rf_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlo_q <= '0;
      rdv_q <= 1'b0;
      rdd_q <= '0;
    end else begin
      dlo_q <= dlo_d;
      rdv_q <= rdv_d;
      rdd_q <= rdd_d;
    end
  end

  assign cmd_ready     = !rdv_q && !wait_block;
  assign rd_valid      = rdv_q;
  assign rd_data       = rdd_q;
  assign mem_req_xfer  = pulses[0];
  assign mem_req_first = pulses[1];
  assign mem_req_full  = pulses[2];

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R4
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_xfer || mem_req_first || mem_req_full) |-> $past(accept && is_mem)); // R6
  AST_READ_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_READ) |=> rd_valid); // R4
  AST_NO_TAKE_WHILE_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cmd_ready); // R4
endmodule

// File: tb/nibcmd_decoder_bench.sv
module nibcmd_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, cmd_ready;
  logic [7:0] cmd_byte;
  logic       rd_valid, rd_ready;
  logic [7:0] rd_data;
  logic       mem_req_xfer, mem_req_first, mem_req_full, mem_bank, mem_done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nibcmd_decoder u_nibcmd_decoder (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .mem_req_xfer(mem_req_xfer), .mem_req_first(mem_req_first),
    .mem_req_full(mem_req_full), .mem_bank(mem_bank), .mem_done(mem_done)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] b, output logic [7:0] v);
    send(b);
    check("R4 rd_valid", 32'(rd_valid), 32'd1);
    v = rd_data;
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    check("R4 rd_valid drop", 32'(rd_valid), 32'd0);
  endtask

  task automatic set_addr(input logic [7:0] a);
    send({4'h0, a[3:0]});
    send({4'h1, a[7:4]});
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_byte = 8'h00; rd_ready = 1'b0; mem_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 / R1 reset state
    check("R1 ready after reset", 32'(cmd_ready), 32'd1);
    check("R9 rd_valid reset", 32'(rd_valid), 32'd0);
    check("R9 pulses reset", 32'({mem_req_xfer, mem_req_first, mem_req_full}), 32'd0);
    // R5: read addr 0 with upward step
    rd(8'h41, v);
    check("R9 reg zero", 32'(v), 32'h00);
    // R3 R5: fill all addresses stepping upward, starting at 1
    for (int k = 1; k <= 256; k++) begin
      send({4'h2, pat(k & 255)[3:0]});
      send({4'h3, pat(k & 255)[7:4]});
    end
    for (int k = 1; k <= 256; k++) begin
      rd(8'h41, v);
      check("R3 R5 sweep up", 32'(v), 32'(pat(k & 255)));
    end
    // R5 downward with wrap
    set_addr(8'h02);
    for (int k = 2; k >= -1; k--) begin
      rd(8'h43, v);
      check("R5 sweep down wrap", 32'(v), 32'(pat(k & 255)));
    end
    // R2 nibble loads; R5 no step for operand 0 and 2
    set_addr(8'hA5);
    set_addr(8'h5A);
    rd(8'h40, v);
    check("R2 addr nibbles", 32'(v), 32'(pat(8'h5A)));
    rd(8'h42, v);
    check("R5 no step dir only", 32'(v), 32'(pat(8'h5A)));
    send(8'h2F); send(8'h3C);
    rd(8'h40, v);
    check("R3 write no step", 32'(v), 32'hCF);
    send(8'h13);
    rd(8'h40, v);
    check("R2 hi nibble only", 32'(v), 32'(pat(8'h3A)));
    // R4 back-pressure
    set_addr(8'h10);
    send(8'h40);
    for (int c = 0; c < 3; c++) begin
      check("R4 hold valid", 32'(rd_valid), 32'd1);
      check("R4 hold data", 32'(rd_data), 32'(pat(8'h10)));
      check("R4 ready low", 32'(cmd_ready), 32'd0);
      @(negedge clk);
    end
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    check("R4 released", 32'(cmd_ready), 32'd1);
    // R6 memory opcodes
    for (int o = 6; o <= 11; o++) begin
      send(8'((o << 4) | 5));
      check("R6 pulses", 32'({mem_req_xfer, mem_req_first, mem_req_full}),
            32'(3'b100 >> ((o - 6) / 2)));
      check("R6 bank", 32'(mem_bank), 32'(o & 1));
      @(negedge clk);
      check("R6 single cycle", 32'({mem_req_xfer, mem_req_first, mem_req_full}), 32'd0);
    end
    mem_done = 1'b1; @(negedge clk); mem_done = 1'b0;
    // R7 wait with nothing outstanding
    send(8'h50);
    check("R7 no stall idle", 32'(cmd_ready), 32'd1);
    // R7 wait with a request outstanding
    send(8'h60);
    send(8'h50);
    for (int c = 0; c < 4; c++) begin
      check("R7 stalled", 32'(cmd_ready), 32'd0);
      @(negedge clk);
    end
    mem_done = 1'b1; @(negedge clk); mem_done = 1'b0;
    check("R7 released", 32'(cmd_ready), 32'd1);
    // R8 unused opcodes
    set_addr(8'h33);
    send(8'h2A);
    for (int b = 8'hC0; b <= 8'hFF; b++) begin
      send(8'(b));
      if ({mem_req_xfer, mem_req_first, mem_req_full, rd_valid} != 4'b0 || !cmd_ready)
        check("R8 no output", 32'({mem_req_xfer, mem_req_first, mem_req_full, rd_valid}), 32'd0);
    end
    checks++;
    send(8'h35);
    rd(8'h40, v);
    check("R8 addr and data kept", 32'(v), 32'h5A);
    // R9 reset mid-operation
    set_addr(8'h77);
    send(8'h60);
    send(8'h21);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9 pulses cleared", 32'({mem_req_xfer, mem_req_first, mem_req_full}), 32'd0);
    send(8'h50);
    check("R9 outstanding cleared", 32'(cmd_ready), 32'd1);
    send(8'h30);
    rd(8'h40, v);
    check("R9 addr and nibble cleared", 32'(v), 32'h00);
    rd(8'h40, v);
    check("R9 step mode none", 32'(v), 32'h00);
    finish_run();
  end
endmodule